// File: doc/BRIEF.md
# Receive Byte Queue with Sticky Overrun Flag

This block sits between the byte-complete output of a serial receiver and a processor's register interface. Each received byte, announced by a one-cycle strobe, is stored in a 16-entry first-in first-out queue. Software pops the queue through a read port that shows the oldest byte, an empty indicator and a fill count from 0 to 16.

If a byte finishes reception while all 16 entries are occupied, the block raises a sticky overrun flag. The stored bytes stay as they are and the new byte is discarded. Reception then stays frozen until software clears the flag. The flag sits in bit 0 of a 16-bit status register. Clearing it takes two steps: first a status read that returns the flag as 1, then a status write with bit 0 at 0. Draining the queue does not clear the flag by itself.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the fill count is 0, the empty indicator is 1, the data output is 0x00 and the status register reads 0x0000.
- R2: A cycle with `rx_done`=1, `rx_en`=1, the flag at 0 and a fill count below 16 stores `rx_byte`, and the count rises by one on the next edge. A strobe with `rx_en`=0 is ignored.
- R3: A `fifo_rd` strobe while the queue is not empty places the oldest stored byte on `fifo_dout` one cycle later and lowers the count by one. Bytes come out in arrival order. A push and a pop in the same cycle leave the count unchanged.
- R4: A `fifo_rd` strobe while the queue is empty leaves `fifo_dout` holding its last value and leaves the count unchanged.
- R5: A cycle with `rx_done`=1 and `rx_en`=1 while the count is 16 sets the flag on the next edge. This uses the count before any pop in the same cycle. The incoming byte is discarded and the 16 stored bytes stay intact.
- R6: While the flag is 1, received bytes are discarded and the fill count never rises.
- R7: A status write with bit 0 at 0 clears the flag only when a status read that returned bit 0 = 1 came earlier, with no status write in between. Any status write uses up that earlier read. A write of 0 without one leaves the flag set.
- R8: A status write with bit 0 at 1 never changes the flag, and it uses up any earlier read.
- R9: The status read data `st_rdata` is combinational. Bits 15 to 1 are always 0, and bit 0 is the flag.
- R10: Dropping `rx_en` to 0 leaves the flag at its current value.
- R11: When an overrun occurs in the same cycle as a valid clearing write, the flag stays 1.
- R12: Popping bytes while the flag is set does not clear the flag. Once the flag is cleared, received bytes are stored again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| rx_done | input | 1 | One-cycle strobe: a byte finished reception |
| rx_byte | input | 8 | Received byte, valid with `rx_done` |
| st_rd | input | 1 | Status register read strobe |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 16 | Status register write data |
| st_rdata | output | 16 | Status register read data |
| fifo_rd | input | 1 | Queue pop strobe |
| fifo_dout | output | 8 | Last byte popped from the queue |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_count | output | 5 | Number of stored bytes, 0 to 16 |

## Verification
The assertions assume that `st_rd` and `st_wr` are never asserted in the same cycle. They also assume that every bus input is a clean one-cycle strobe, sampled at the rising edge. The stimulus drives each status access as its own single-cycle strobe and never combines a read with a write. It does combine receive strobes with pops and with clearing writes, so that the pop-versus-overrun ordering and the case where the set wins over the clear are both covered. The reference model in the bench uses the same convention. Its expected values do not depend on what a simultaneous read and write would do.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DEPTH = 16;
    localparam int RXQ_DW    = 8;
    localparam int RXQ_SRW   = 16;

    typedef struct packed {
        logic ovr;
        logic armed;
    } flag_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    parameter int DW    = rxq_pkg::RXQ_DW,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic [DW-1:0] dout
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            dout;
    } store_t;

    store_t s_d, s_q;
    logic   pop_ok;
    logic   push_ok;

    // Advance a pointer and wrap it at the last entry.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        pop_ok  = pop  && (s_q.cnt != '0);
        push_ok = push && (s_q.cnt != CAP);
        if (push_ok) begin
            s_d.mem[s_q.wr] = push_data;
            s_d.wr          = bump(s_q.wr);
        end
        if (pop_ok) begin
            s_d.dout = s_q.mem[s_q.rd];
            s_d.rd   = bump(s_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full  = (s_q.cnt == CAP);
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
    assign dout  = s_q.dout;
endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag #(
    parameter int SRW = rxq_pkg::RXQ_SRW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ovr_evt,
    input  logic           st_rd,
    input  logic           st_wr,
    input  logic           wr_bit0,
    output logic [SRW-1:0] st_rdata,
    output logic           ovr
);
    import rxq_pkg::*;

    flag_state_t f_d, f_q;
    logic        clr_ok;

    always_comb begin
        f_d    = f_q;
        // Clearing needs an earlier read of 1 and a written 0.
        clr_ok = st_wr && f_q.armed && !wr_bit0;
        // Any write uses up the arm; a read that sees 1 arms.
        f_d.armed = (f_q.armed && !st_wr) || (st_rd && f_q.ovr);
        if (ovr_evt)     f_d.ovr = 1'b1;
        else if (clr_ok) f_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign st_rdata = {{(SRW-1){1'b0}}, f_q.ovr};
    assign ovr      = f_q.ovr;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    parameter int DW    = rxq_pkg::RXQ_DW,
    parameter int SRW   = rxq_pkg::RXQ_SRW,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_en,
    input  logic           rx_done,
    input  logic [DW-1:0]  rx_byte,
    input  logic           st_rd,
    input  logic           st_wr,
    input  logic [SRW-1:0] st_wdata,
    output logic [SRW-1:0] st_rdata,
    input  logic           fifo_rd,
    output logic [DW-1:0]  fifo_dout,
    output logic           fifo_empty,
    output logic [CW-1:0]  fifo_count
);
    logic rx_take;
    logic full;
    logic ovr;
    logic ovr_evt;
    logic push;
    logic wdata_hi_unused;

    assign rx_take = rx_done && rx_en;
    assign ovr_evt = rx_take && full;
    assign push    = rx_take && !full && !ovr;
    assign wdata_hi_unused = ^st_wdata[SRW-1:1];

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_byte),
        .pop       (fifo_rd),
        .full      (full),
        .empty     (fifo_empty),
        .count     (fifo_count),
        .dout      (fifo_dout)
    );

    rxq_ovr_flag #(.SRW(SRW)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_evt  (ovr_evt),
        .st_rd    (st_rd),
        .st_wr    (st_wr),
        .wr_bit0  (st_wdata[0]),
        .st_rdata (st_rdata),
        .ovr      (ovr)
    );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
    parameter int DW    = rxq_pkg::RXQ_DW,
    parameter int SRW   = rxq_pkg::RXQ_SRW,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_en,
    input logic           rx_done,
    input logic           st_rd,
    input logic           st_wr,
    input logic [SRW-1:0] st_wdata,
    input logic [SRW-1:0] st_rdata,
    input logic           fifo_rd,
    input logic [DW-1:0]  fifo_dout,
    input logic           fifo_empty,
    input logic [CW-1:0]  fifo_count
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count <= CAP) && (fifo_empty == (fifo_count == '0)));

    assert_pop_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_empty) |=> $stable(fifo_dout));

    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && fifo_count == CAP) |=> st_rdata[0]);

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_rdata[0] |=> (fifo_count <= $past(fifo_count)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rdata[0] && !(st_wr && !st_wdata[0])) |=> st_rdata[0]);

    assert_write_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_wdata[0]) |=> (st_rdata[0] == $past(st_rdata[0])));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_rdata[SRW-1:1] == '0);

    assert_enable_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !st_wr) |=> $stable(st_rdata[0]));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rdata[0] && st_wr && rx_done && rx_en && fifo_count == CAP) |=> st_rdata[0]);

    assert_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_rd && st_wr));
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH), .DW(DW), .SRW(SRW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rx_done    (rx_done),
    .st_rd      (st_rd),
    .st_wr      (st_wr),
    .st_wdata   (st_wdata),
    .st_rdata   (st_rdata),
    .fifo_rd    (fifo_rd),
    .fifo_dout  (fifo_dout),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count)
);

// File: tb/rx_byte_queue_bench.sv
module rx_byte_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        rx_done = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        st_rd = 1'b0;
    logic        st_wr = 1'b0;
    logic [15:0] st_wdata = 16'h0000;
    logic [15:0] st_rdata;
    logic        fifo_rd = 1'b0;
    logic [7:0]  fifo_dout;
    logic        fifo_empty;
    logic [4:0]  fifo_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference model state
    byte unsigned m_q[$];
    logic [7:0]   m_dout = 8'h00;
    bit           m_flag = 1'b0;
    bit           m_armed = 1'b0;

    always #10 clk = ~clk;

    rx_byte_queue u_rx_byte_queue (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_done(rx_done), .rx_byte(rx_byte),
        .st_rd(st_rd), .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "count", int'(fifo_count), m_q.size());
        check(tag, "empty", int'(fifo_empty), int'(m_q.size() == 0));
        check(tag, "dout", int'(fifo_dout), int'(m_dout));
        check(tag, "status", int'(st_rdata), int'(m_flag));
    endtask

    // One clock: update the model from the driven inputs, then compare.
    task automatic cyc(string tag);
        bit take, full, push, pop, clr;
        take = rx_done && rx_en;
        full = (m_q.size() == 16);
        push = take && !full && !m_flag;
        pop  = fifo_rd && (m_q.size() > 0);
        clr  = st_wr && m_armed && !st_wdata[0];
        if (pop)  m_dout = m_q.pop_front();
        if (push) m_q.push_back(rx_byte);
        m_armed = (m_armed && !st_wr) || (st_rd && m_flag);
        if (take && full) m_flag = 1'b1;
        else if (clr)     m_flag = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        rx_done = 1'b0; fifo_rd = 1'b0; st_rd = 1'b0; st_wr = 1'b0;
    endtask

    task automatic push_b(logic [7:0] b, string tag);
        rx_done = 1'b1; rx_byte = b; cyc(tag);
    endtask
    task automatic pop_b(string tag);
        fifo_rd = 1'b1; cyc(tag);
    endtask
    task automatic st_read(string tag);
        st_rd = 1'b1; cyc(tag);
    endtask
    task automatic st_write(logic [15:0] v, string tag);
        st_wr = 1'b1; st_wdata = v; cyc(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        check("R9", "status_hi", int'(st_rdata[15:1]), 0);

        // R2: basic pushes, one with the receiver disabled
        rx_en = 1'b1;
        for (int i = 0; i < 5; i++) push_b(8'h10 + 8'(i), "R2");
        rx_en = 1'b0; push_b(8'hEE, "R2");
        rx_en = 1'b1;
        // R3: pops in order, plus push and pop together
        for (int i = 0; i < 3; i++) pop_b("R3");
        rx_done = 1'b1; rx_byte = 8'h77; fifo_rd = 1'b1; cyc("R3");
        while (m_q.size() > 0) pop_b("R3");
        // R4: pops while empty
        pop_b("R4"); pop_b("R4");

        // R5: fill to 16, then overrun
        for (int i = 0; i < 16; i++) push_b(8'hA0 + 8'(i), "R2");
        push_b(8'h5A, "R5");
        // R6: more bytes are dropped while the flag is set
        push_b(8'h5B, "R6");
        pop_b("R12"); pop_b("R12");
        push_b(8'h5C, "R6");
        rx_done = 1'b1; rx_byte = 8'h5D; fifo_rd = 1'b1; cyc("R6");
        // R10: receiver disabled leaves the flag alone
        rx_en = 1'b0; cyc("R10"); push_b(8'h11, "R10"); rx_en = 1'b1;
        // R7: a write of 0 without a read of 1 does nothing
        st_write(16'h0000, "R7");
        // R8: read arms, then a write of 1 uses up the arm without clearing
        st_read("R8"); st_write(16'h0001, "R8");
        st_write(16'h0000, "R7");
        // R9: upper bits ignore writes
        st_read("R9"); st_write(16'hFFFE, "R9");
        // R12: reception resumes after the clear
        push_b(8'hC3, "R12");
        pop_b("R12");

        // R11: refill, overrun, then a clearing write together with another overrun
        while (m_q.size() < 16) push_b(8'(m_q.size()) ^ 8'h3C, "R2");
        push_b(8'h99, "R5");
        st_read("R11");
        st_wr = 1'b1; st_wdata = 16'h0000; rx_done = 1'b1; rx_byte = 8'h98; cyc("R11");
        st_read("R7"); st_write(16'h0000, "R7");
        // R5: the overrun check uses the count before a same-cycle pop
        rx_done = 1'b1; rx_byte = 8'h97; fifo_rd = 1'b1; cyc("R5");
        st_read("R7"); st_write(16'h0000, "R7");
        while (m_q.size() > 0) pop_b("R3");
        pop_b("R4");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule